// File: doc/BRIEF.md
# Dual-Channel Reloadable Down-Counter Timer

This block is a memory-mapped timer with two independent down-counting channels. Each channel holds a live count, a programmable period value and a control word. On every pulse of the tick source its control word selects, the live count steps down by one. When the count steps from one to zero the channel raises a sticky event flag. On its next tick the channel either copies the period back into the live count, giving a repeating period of period+1 ticks, or stays at zero. With reload enabled and a period of all ones, a channel is a free-running timebase.

Software reaches every writable register three ways: a plain write, a set alias that ORs in the written ones, and a clear alias that removes the written ones. Single control bits can therefore change without a read-modify-write. An update mode makes a new period take effect at once instead of at the next reload. A block-level hold bit forces both channels into an idle, all-zero state. A read-only identity word reports the major revision. One interrupt line combines the enabled flags of both channels.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every register reads zero except the identity word, bus_rvalid is low and irq is low.
- R2: A read with bus_rd high returns its data on bus_rdata, with bus_rvalid high, in the cycle after the request. Channel n's control word is at 0x20+n*0x40, its live count at 0x30+n*0x40 and its period at 0x40+n*0x40. The block control word is at 0x00 and the identity word at 0xC0. A read of an alias returns the register's value and an unmapped read returns zero.
- R3: The control word holds the tick select in bits 3:0. With select s, not 0, each cycle in which tick_in[s] is high decrements a nonzero live count by one. Select 0 never counts, and ticks on other inputs have no effect.
- R4: The event flag (control bit 15) sets when the live count goes from 1 to 0 on a tick. It stays set through plain writes and set-alias writes of any value. Only a clear-alias write with bit 15 set clears it. A hardware set in the same cycle wins.
- R5: A tick at a live count of zero loads the period when reload (bit 6) is set. With reload clear, the count stays at zero and no further flag is raised.
- R6: With update (bit 7) set, any write to the period also loads the new period into the live count on the same clock edge. With update clear, the live count is untouched by period writes.
- R7: For the control words, periods and block control word, the register at base+4 ORs the written ones in and the register at base+8 clears the written ones. The live counts and identity word are read-only.
- R8: irq is high exactly when some channel has both its event flag and its interrupt enable (bit 14) set.
- R9: While block control bit 31 (hold) is set, both channels are forced to all-zero state and ignore writes. After hold is cleared they accept writes again.
- R10: The identity word reads 0x02 in bits 31:24 and the minor parameter (default 0) below, and ignores writes.
- R11: The two channels count, flag and reload independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request this cycle |
| bus_rd | input | 1 | Read request this cycle |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| tick_in | input | 2**SEL_W | Tick pulses, one per source, synchronous to clk |
| irq | output | 1 | Combined interrupt request |

## Verification
The properties assume that tick inputs are single-cycle pulses synchronous to clk and that bus addresses are word aligned. They also assume that a flag clear is seen only through a clear-alias write that carries bit 15. The bench drives every input on the falling edge, with one bus operation at a time and ticks lasting exactly one cycle. It reads results back through the register map, so the sticky, stopped and held states are observed through the same decode that software uses.

// File: rtl/dt_pkg.sv
package dt_pkg;

    localparam int REG_W = 32;

    localparam logic [15:0] BLK_CTRL_OFS  = 16'h000;
    localparam logic [15:0] CH_CTRL_OFS   = 16'h020;
    localparam logic [15:0] CH_RUN_OFS    = 16'h030;
    localparam logic [15:0] CH_PERIOD_OFS = 16'h040;
    localparam logic [15:0] CH_STRIDE     = 16'h040;
    localparam logic [15:0] IDENT_OFS     = 16'h0C0;
    localparam logic [15:0] SET_ALIAS     = 16'h004;
    localparam logic [15:0] CLR_ALIAS     = 16'h008;

    localparam int CTRL_RELOAD_BIT = 6;
    localparam int CTRL_UPDATE_BIT = 7;
    localparam int CTRL_IE_BIT     = 14;
    localparam int CTRL_FLAG_BIT   = 15;
    localparam int BLK_HOLD_BIT    = 31;
    localparam logic [7:0] MAJOR_REV = 8'h02;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } wr_op_e;

    function automatic logic [REG_W-1:0] apply_op(wr_op_e op,
                                                  logic [REG_W-1:0] cur,
                                                  logic [REG_W-1:0] wd);
        case (op)
            OP_WRITE: return wd;
            OP_SET:   return cur | wd;
            OP_CLEAR: return cur & ~wd;
            default:  return cur;
        endcase
    endfunction

    function automatic wr_op_e alias_op(logic [15:0] a, logic [15:0] base);
        if (a == base)                  return OP_WRITE;
        else if (a == base + SET_ALIAS) return OP_SET;
        else if (a == base + CLR_ALIAS) return OP_CLEAR;
        else                            return OP_NONE;
    endfunction

endpackage

// File: rtl/dt_addr_dec.sv
module dt_addr_dec
    import dt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 12
) (
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    output wr_op_e               blk_op,
    output wr_op_e [NUM_CH-1:0]  ctrl_op,
    output wr_op_e [NUM_CH-1:0]  period_op
);
    logic [15:0] a16;
    assign a16 = 16'(addr);

    assign blk_op = wr ? alias_op(a16, BLK_CTRL_OFS) : OP_NONE;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [15:0] CTRL_BASE   = 16'(CH_CTRL_OFS + i * CH_STRIDE);
        localparam logic [15:0] PERIOD_BASE = 16'(CH_PERIOD_OFS + i * CH_STRIDE);
        assign ctrl_op[i]   = wr ? alias_op(a16, CTRL_BASE)   : OP_NONE;
        assign period_op[i] = wr ? alias_op(a16, PERIOD_BASE) : OP_NONE;
    end
endmodule

// File: rtl/dt_channel.sv
module dt_channel
    import dt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SEL_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hold,
    input  logic [(1<<SEL_W)-1:0] tick_in,
    input  wr_op_e                ctrl_op,
    input  wr_op_e                period_op,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      ctrl_word,
    output logic [CNT_W-1:0]      run_cnt,
    output logic [CNT_W-1:0]      period,
    output logic                  flag,
    output logic                  ie,
    output logic                  reload
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             reload;
        logic             update;
        logic             ie;
        logic             flag;
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] period;
    } ch_state_t;

    ch_state_t ch_d, ch_q;
    logic [REG_W-1:0] cur_word;
    logic [REG_W-1:0] new_word;
    logic [REG_W-1:0] new_period;
    logic             tick;
    logic             hit_zero;

    always_comb begin
        cur_word                  = '0;
        cur_word[SEL_W-1:0]       = ch_q.sel;
        cur_word[CTRL_RELOAD_BIT] = ch_q.reload;
        cur_word[CTRL_UPDATE_BIT] = ch_q.update;
        cur_word[CTRL_IE_BIT]     = ch_q.ie;
        cur_word[CTRL_FLAG_BIT]   = ch_q.flag;
    end

    always_comb begin
        ch_d       = ch_q;
        hit_zero   = 1'b0;
        tick       = (ch_q.sel != '0) && tick_in[ch_q.sel];
        new_word   = apply_op(ctrl_op, cur_word, wdata);
        new_period = apply_op(period_op, REG_W'(ch_q.period), wdata);

        if (ctrl_op != OP_NONE) begin
            ch_d.sel    = new_word[SEL_W-1:0];
            ch_d.reload = new_word[CTRL_RELOAD_BIT];
            ch_d.update = new_word[CTRL_UPDATE_BIT];
            ch_d.ie     = new_word[CTRL_IE_BIT];
            if (ctrl_op == OP_CLEAR && wdata[CTRL_FLAG_BIT])
                ch_d.flag = 1'b0;
        end

        if (period_op != OP_NONE)
            ch_d.period = new_period[CNT_W-1:0];

        if (tick) begin
            if (ch_q.run == '0) begin
                if (ch_q.reload)
                    ch_d.run = ch_q.period;
            end else begin
                ch_d.run = ch_q.run - 1'b1;
                hit_zero = (ch_q.run == CNT_W'(1));
            end
        end

        if (period_op != OP_NONE && ch_q.update)
            ch_d.run = new_period[CNT_W-1:0];

        if (hit_zero)
            ch_d.flag = 1'b1;

        if (hold)
            ch_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign ctrl_word = cur_word;
    assign run_cnt   = ch_q.run;
    assign period    = ch_q.period;
    assign flag      = ch_q.flag;
    assign ie        = ch_q.ie;
    assign reload    = ch_q.reload;
endmodule

// File: rtl/dt_rd_mux.sv
module dt_rd_mux
    import dt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic [REG_W-1:0]                 blk_word,
    input  logic [REG_W-1:0]                 ident_word,
    input  logic [NUM_CH-1:0][REG_W-1:0]     ctrl_words,
    input  logic [NUM_CH-1:0][CNT_W-1:0]     run_vec,
    input  logic [NUM_CH-1:0][CNT_W-1:0]     period_vec,
    output logic [REG_W-1:0]                 rd_word
);
    logic [15:0] a16;
    logic [NUM_CH-1:0][REG_W-1:0] ch_word;

    assign a16 = 16'(addr);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [15:0] CTRL_BASE   = 16'(CH_CTRL_OFS + i * CH_STRIDE);
        localparam logic [15:0] RUN_BASE    = 16'(CH_RUN_OFS + i * CH_STRIDE);
        localparam logic [15:0] PERIOD_BASE = 16'(CH_PERIOD_OFS + i * CH_STRIDE);
        always_comb begin
            ch_word[i] = '0;
            if (alias_op(a16, CTRL_BASE) != OP_NONE)
                ch_word[i] = ctrl_words[i];
            else if (alias_op(a16, RUN_BASE) != OP_NONE)
                ch_word[i] = REG_W'(run_vec[i]);
            else if (alias_op(a16, PERIOD_BASE) != OP_NONE)
                ch_word[i] = REG_W'(period_vec[i]);
        end
    end

    always_comb begin
        rd_word = '0;
        if (alias_op(a16, BLK_CTRL_OFS) != OP_NONE)
            rd_word = blk_word;
        else if (alias_op(a16, IDENT_OFS) != OP_NONE)
            rd_word = ident_word;
        for (int i = 0; i < NUM_CH; i++)
            rd_word = rd_word | ch_word[i];
    end
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
    import dt_pkg::*;
#(
    parameter int          NUM_CH    = 2,
    parameter int          CNT_W     = 32,
    parameter int          SEL_W     = 4,
    parameter int          ADDR_W    = 12,
    parameter logic [23:0] MINOR_VER = 24'h0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  bus_rvalid,
    input  logic [(1<<SEL_W)-1:0] tick_in,
    output logic                  irq
);
    localparam logic [REG_W-1:0] IDENT_WORD = {MAJOR_REV, MINOR_VER};

    typedef struct packed {
        logic             hold;
        logic             rvalid;
        logic [REG_W-1:0] rdata;
    } top_state_t;

    top_state_t top_d, top_q;

    wr_op_e                       blk_op;
    wr_op_e [NUM_CH-1:0]          ctrl_op;
    wr_op_e [NUM_CH-1:0]          period_op;
    logic [NUM_CH-1:0][REG_W-1:0] ctrl_words;
    logic [NUM_CH-1:0][CNT_W-1:0] run_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] period_vec;
    logic [NUM_CH-1:0]            flag_vec;
    logic [NUM_CH-1:0]            ie_vec;
    logic [NUM_CH-1:0]            reload_vec;
    logic [NUM_CH-1:0]            period_wr_vec;
    logic [NUM_CH-1:0]            flag_clr_vec;
    logic [REG_W-1:0]             blk_word;
    logic [REG_W-1:0]             blk_new;
    logic [REG_W-1:0]             rd_word;
    logic                         soft_hold;

    dt_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .wr        (bus_wr),
        .addr      (bus_addr),
        .blk_op    (blk_op),
        .ctrl_op   (ctrl_op),
        .period_op (period_op)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dt_channel #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold      (soft_hold),
            .tick_in   (tick_in),
            .ctrl_op   (ctrl_op[i]),
            .period_op (period_op[i]),
            .wdata     (bus_wdata),
            .ctrl_word (ctrl_words[i]),
            .run_cnt   (run_vec[i]),
            .period    (period_vec[i]),
            .flag      (flag_vec[i]),
            .ie        (ie_vec[i]),
            .reload    (reload_vec[i])
        );
        assign period_wr_vec[i] = (period_op[i] != OP_NONE);
        assign flag_clr_vec[i]  = (ctrl_op[i] == OP_CLEAR) && bus_wdata[CTRL_FLAG_BIT];
    end

    dt_rd_mux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_mux (
        .addr       (bus_addr),
        .blk_word   (blk_word),
        .ident_word (IDENT_WORD),
        .ctrl_words (ctrl_words),
        .run_vec    (run_vec),
        .period_vec (period_vec),
        .rd_word    (rd_word)
    );

    always_comb begin
        blk_word               = '0;
        blk_word[BLK_HOLD_BIT] = top_q.hold;
        blk_new                = apply_op(blk_op, blk_word, bus_wdata);
    end

    always_comb begin
        top_d        = top_q;
        top_d.hold   = blk_new[BLK_HOLD_BIT];
        top_d.rvalid = bus_rd;
        if (bus_rd)
            top_d.rdata = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign soft_hold  = top_q.hold;
    assign bus_rdata  = top_q.rdata;
    assign bus_rvalid = top_q.rvalid;
    assign irq        = |(flag_vec & ie_vec);
endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           rd_en,
    input logic                           rd_valid,
    input logic                           hold,
    input logic [NUM_CH-1:0][CNT_W-1:0]   run_vec,
    input logic [NUM_CH-1:0]              flag_vec,
    input logic [NUM_CH-1:0]              reload_vec,
    input logic [NUM_CH-1:0]              period_wr_vec,
    input logic [NUM_CH-1:0]              flag_clr_vec
);
    // R2: read data follows the request by exactly one cycle
    a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r2_no_spurious_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R9: hold forces channels idle
    a_r9_hold_idles: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (run_vec == '0 && flag_vec == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R4: flag survives anything but a clear-alias write of bit 15
        a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_vec[i] && !flag_clr_vec[i] && !hold) |=> flag_vec[i]);
        // R5: a stopped one-shot channel stays at zero
        a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (run_vec[i] == '0 && !reload_vec[i] && !period_wr_vec[i] && !hold)
            |=> run_vec[i] == '0);
    end
endmodule

bind dual_down_timer dt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en         (bus_rd),
    .rd_valid      (bus_rvalid),
    .hold          (soft_hold),
    .run_vec       (run_vec),
    .flag_vec      (flag_vec),
    .reload_vec    (reload_vec),
    .period_wr_vec (period_wr_vec),
    .flag_clr_vec  (flag_clr_vec)
);

// File: tb/dual_down_timer_tb_top.sv
`timescale 1ns/1ps
module dual_down_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [15:0] tick_in = '0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [31:0] exp;
        logic [11:0] addr;
        string       tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #4 clk = ~clk;

    dual_down_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .tick_in(tick_in), .irq(irq)
    );

    // monitor: pops one expectation per returned read
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_tests++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read data %h (no expectation)", bus_rdata);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr %h: got %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        it.exp = e; it.addr = a; it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick(input logic [15:0] m);
        @(negedge clk);
        tick_in = m;
        @(negedge clk);
        tick_in = '0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        @(negedge clk);
        n_tests++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s irq: got %b expected %b", tag, irq, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R10: reset state and identity
        expect_rd(12'h020, 32'h0, "R1 ctrl0");
        expect_rd(12'h030, 32'h0, "R1 run0");
        expect_rd(12'h040, 32'h0, "R1 period0");
        expect_rd(12'h000, 32'h0, "R1 blkctrl");
        expect_rd(12'h0C0, 32'h0200_0000, "R10 ident");
        expect_rd(12'h0F0, 32'h0, "R2 unmapped");
        check_irq(1'b0, "R1");

        // R7: aliases on ctrl and period (update set so R6 load visible)
        wr(12'h020, 32'h0000_000B);
        wr(12'h024, 32'h0000_00C0);
        expect_rd(12'h020, 32'h0000_00CB, "R7 ctrl set alias");
        expect_rd(12'h024, 32'h0000_00CB, "R2 alias read");
        wr(12'h040, 32'h10);
        wr(12'h044, 32'h03);
        wr(12'h048, 32'h01);
        expect_rd(12'h040, 32'h12, "R7 period set/clear alias");
        expect_rd(12'h030, 32'h12, "R6 update loads live count");

        // R6: update clear, live count untouched; R7 clear alias on ctrl
        wr(12'h028, 32'h0000_0080);
        expect_rd(12'h020, 32'h0000_004B, "R7 ctrl clear alias");
        wr(12'h040, 32'h5);
        expect_rd(12'h030, 32'h12, "R6 no update");
        wr(12'h030, 32'h77);
        expect_rd(12'h030, 32'h12, "R7 live count read-only");

        // R3: counting on selected source only
        tick(16'h0800); tick(16'h0800); tick(16'h0800);
        expect_rd(12'h030, 32'h0F, "R3 three ticks");
        tick(16'h0008);
        expect_rd(12'h030, 32'h0F, "R3 other source ignored");

        // R3 / R11: channel 1 with select 0 never counts
        wr(12'h060, 32'h0000_0080);
        wr(12'h080, 32'h7);
        tick(16'hFFFF); tick(16'hFFFF);
        expect_rd(12'h070, 32'h7, "R3 select zero idle");
        expect_rd(12'h030, 32'h0D, "R11 ch0 independent");

        // R4 / R5 / R8: one-shot on channel 1
        wr(12'h060, 32'h0000_0082);
        wr(12'h080, 32'h2);
        expect_rd(12'h070, 32'h2, "R6 ch1 update");
        tick(16'h0004); tick(16'h0004);
        expect_rd(12'h070, 32'h0, "R4 reached zero");
        expect_rd(12'h060, 32'h0000_8082, "R4 flag set");
        check_irq(1'b0, "R8 enable off");
        tick(16'h0004);
        expect_rd(12'h070, 32'h0, "R5 one-shot stays zero");
        wr(12'h064, 32'h0000_4000);
        check_irq(1'b1, "R8 enabled flag");
        wr(12'h060, 32'h0000_4082);
        expect_rd(12'h060, 32'h0000_C082, "R4 plain write keeps flag");
        wr(12'h068, 32'h0000_8000);
        expect_rd(12'h060, 32'h0000_4082, "R4 clear alias");
        check_irq(1'b0, "R8 flag cleared");
        wr(12'h060, 32'h0000_C082);
        expect_rd(12'h060, 32'h0000_4082, "R4 plain write cannot set");

        // R5: reload on channel 0
        wr(12'h024, 32'h0000_0080);
        wr(12'h040, 32'h2);
        wr(12'h028, 32'h0000_0080);
        tick(16'h0800); tick(16'h0800);
        expect_rd(12'h030, 32'h0, "R5 reached zero");
        expect_rd(12'h020, 32'h0000_804B, "R4 ch0 flag");
        tick(16'h0800);
        expect_rd(12'h030, 32'h2, "R5 reload");
        check_irq(1'b0, "R8 ch0 enable off");
        wr(12'h024, 32'h0000_4000);
        check_irq(1'b1, "R8 ch0 enabled");

        // R9: hold
        wr(12'h000, 32'h8000_0000);
        expect_rd(12'h000, 32'h8000_0000, "R9 hold reads back");
        expect_rd(12'h020, 32'h0, "R9 ctrl0 idle");
        expect_rd(12'h030, 32'h0, "R9 run0 idle");
        check_irq(1'b0, "R9 irq idle");
        wr(12'h040, 32'h9);
        expect_rd(12'h040, 32'h0, "R9 write ignored");
        wr(12'h008, 32'h8000_0000);
        expect_rd(12'h000, 32'h0, "R9 hold cleared");
        wr(12'h040, 32'h9);
        expect_rd(12'h040, 32'h9, "R9 writes accepted again");

        // R10: identity ignores writes
        wr(12'h0C0, 32'h0);
        expect_rd(12'h0C0, 32'h0200_0000, "R10 read-only");

        // R5 / R3: free-running timebase
        wr(12'h020, 32'h0000_00CB);
        wr(12'h040, 32'hFFFF_FFFF);
        tick(16'h0800);
        expect_rd(12'h030, 32'hFFFF_FFFE, "R3 free-running");
        expect_rd(12'h020, 32'h0000_00CB, "R4 no flag while running");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d reads never returned", sb_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule